// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block moves 32-bit words for one peripheral between a small internal FIFO and a memory request port, in either direction. Software programs it through four 32-bit registers: a control/status word, a running transfer address, a byte counter and a free scratch register. Once the enable bit is set, the engine groups memory beats into bursts whose length comes from a field in the control word. It advances the address and the byte counter on every accepted beat, and it stops on terminal count or when the next beat would leave the 16 MB window that holds the start address.

The register port is a simple synchronous write strobe with a two-bit word index (index = byte offset / 4) and combinational read data. The peripheral side has two valid/ready word streams, one into the FIFO and one out of it. The memory side uses a valid/ready handshake. Each beat carries an address, a write flag and the burst length in words. For read beats, memory returns data in the cycle the beat is accepted. An interrupt line reports terminal count and error, gated by an enable bit.

Top module: `dma_channel`

## Requirements
- R1: After reset, the control word reads 0xA000_0000, with the device ID 0xA in bits 31:28 and every other bit 0. Address, count and scratch read 0, `irq` is low and `mem_req_valid` is low.
- R2: Word index 0 is control, 1 is address (32 bits), 2 is count (24 bits, upper bits read 0) and 3 is scratch (32 bits), all read/write. In control, writable bits 4, 8, 9, 13, 18, 19 and 23 read back as written, bit 5 reads 0, and writes to bits 31:28 are ignored.
- R3: While control bit 9 is 0, `mem_req_valid` stays low, and address and count hold their values.
- R4: Control bit 8 = 1 moves words from `dev_in` to memory with `mem_req_write`=1, in arrival order. Bit 8 = 0 issues read beats with `mem_req_write`=0 and delivers the returned words on `dev_out` in beat order.
- R5: Each accepted beat presents the running address and moves min(4, count) bytes (4 when bit 13 is 0). Address bits 23:0 advance by that amount, and the count drops by it when bit 13 is 1.
- R6: Bits 19:18 choose the burst: 00 gives 4 words, 01 gives 8, 11 gives 16 and 10 gives 1. A burst's `mem_req_len` is the smaller of that value and ceil(count/4), taken when the burst starts, and the burst's beats carry that same length.
- R7: With bit 13 set, the beat that takes the count to 0 sets bit 14. It also sets bit 0 unless bit 23 is 1. No further beats are issued.
- R8: A beat never carries address bits 23:0 past 2^24. A transfer that ends exactly at the window edge completes normally, with address bits 23:0 reading 0 and bits 31:24 unchanged. One that needs more sets bit 1, stops, and keeps the remaining count.
- R9: `irq` equals bit 4 AND (bit 0 OR bit 1).
- R10: Writing 1 to bit 0, 1 or 14 clears that flag, and writing 0 leaves it. A set event in the same cycle as the clear wins.
- R11: Writing 1 to bit 5 empties the FIFO, so words held before it never reach memory or the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| dev_in_valid | input | 1 | Peripheral word offered to the FIFO |
| dev_in_ready | output | 1 | FIFO accepts a peripheral word |
| dev_in_data | input | 32 | Peripheral word in |
| dev_out_valid | output | 1 | FIFO word offered to the peripheral |
| dev_out_ready | input | 1 | Peripheral takes the word |
| dev_out_data | output | 32 | Word out to the peripheral |
| mem_req_valid | output | 1 | Memory beat requested |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_req_addr | output | 32 | Byte address of the beat |
| mem_req_write | output | 1 | 1 = write to memory, 0 = read |
| mem_req_len | output | 5 | Burst length in words |
| mem_wdata | output | 32 | Write data for the beat |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |
| irq | output | 1 | Interrupt request |

## Verification
The terminal-count flag and its interrupt flag can be set by the last beat in the same cycle that software writes 1s to clear them. The bench holds the memory side stalled on a single-word final beat. It then raises `mem_req_ready` and the control write together, so both take effect at one clock edge. The bench judges the outcome by reading the control word afterwards, where bits 0 and 14 must still be set and `irq` high. A second clear must then remove both flags.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter logic [3:0] DEV_ID     = 4'hA,
  parameter int         FIFO_DEPTH = 16,
  parameter int         WIN_W      = 24,
  parameter int         CNT_W      = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        dev_in_valid,
  output logic        dev_in_ready,
  input  logic [31:0] dev_in_data,
  output logic        dev_out_valid,
  input  logic        dev_out_ready,
  output logic [31:0] dev_out_data,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  output logic        mem_req_write,
  output logic [4:0]  mem_req_len,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        irq
);

  localparam int AW = $clog2(FIFO_DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(FIFO_DEPTH);
  localparam logic [WIN_W:0] WIN = (WIN_W+1)'(1) << WIN_W;

  logic wr_ctl, wr_adr, wr_cnt, wr_tst;
  assign wr_ctl = reg_wr && reg_idx == 2'd0;
  assign wr_adr = reg_wr && reg_idx == 2'd1;
  assign wr_cnt = reg_wr && reg_idx == 2'd2;
  assign wr_tst = reg_wr && reg_idx == 2'd3;

  logic f_irq, f_err, f_tc, ie, dir, en, cnt_en, tc_quiet;
  logic [1:0] bsel;
  logic [31:0] addr_q, test_q;
  logic [CNT_W-1:0] cnt_q;
  logic edge_q;

  logic [31:0] fifo [FIFO_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] fcnt;

  logic in_burst;
  logic [4:0] left_q, blen_q;

  logic [4:0] bwords;
  always_comb begin
    case (bsel)
      2'b00:   bwords = 5'd4;
      2'b01:   bwords = 5'd8;
      2'b11:   bwords = 5'd16;
      default: bwords = 5'd1;
    endcase
  end

  logic [CNT_W:0] rem_words;
  logic [4:0] blen_next;
  logic [AW:0] space;
  logic room_ok, go;
  assign rem_words = ({1'b0, cnt_q} + (CNT_W+1)'(3)) >> 2;
  assign blen_next = (cnt_en && rem_words < (CNT_W+1)'(bwords)) ? rem_words[4:0] : bwords;
  assign space     = FULL - fcnt;
  assign room_ok   = dir ? (fcnt >= (AW+1)'(blen_next)) : (space >= (AW+1)'(blen_next));
  assign go        = en && !f_err && (!cnt_en || cnt_q != '0);

  logic [2:0] step;
  logic [WIN_W:0] nxt;
  logic over, due, fire, hit_err, flush, abort, last;
  assign step    = (cnt_en && cnt_q < CNT_W'(4)) ? cnt_q[2:0] : 3'd4;
  assign nxt     = {1'b0, addr_q[WIN_W-1:0]} + (WIN_W+1)'(step);
  assign over    = edge_q || nxt > WIN;
  assign due     = in_burst && en;
  assign mem_req_valid = due && !over;
  assign fire    = mem_req_valid && mem_req_ready;
  assign hit_err = due && over;
  assign flush   = wr_ctl && reg_wdata[5];
  assign abort   = flush || wr_adr || wr_cnt;
  assign last    = fire && cnt_en && cnt_q == CNT_W'(step);

  assign mem_req_addr  = addr_q;
  assign mem_req_write = dir;
  assign mem_req_len   = blen_q;

  logic push, pop;
  logic [31:0] pdata, head;
  assign dev_in_ready  = dir && fcnt != FULL;
  assign dev_out_valid = !dir && fcnt != '0;
  assign push  = dir ? (dev_in_valid && dev_in_ready) : fire;
  assign pop   = dir ? fire : (dev_out_valid && dev_out_ready);
  assign pdata = dir ? dev_in_data : mem_rdata;
  assign head  = fifo[rp];
  assign mem_wdata    = head;
  assign dev_out_data = head;

  always_ff @(posedge clk) begin
    if (push) fifo[wp] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      fcnt <= fcnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_burst <= 1'b0; left_q <= '0; blen_q <= '0;
    end else if (abort || hit_err || !en) begin
      in_burst <= 1'b0;
    end else if (!in_burst) begin
      if (go && room_ok && blen_next != '0) begin
        in_burst <= 1'b1; left_q <= blen_next; blen_q <= blen_next;
      end
    end else if (fire) begin
      left_q <= left_q - 5'd1;
      if (left_q == 5'd1) in_burst <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; edge_q <= 1'b0; cnt_q <= '0; test_q <= '0;
    end else begin
      if (wr_adr) begin
        addr_q <= reg_wdata; edge_q <= 1'b0;
      end else if (fire) begin
        addr_q[WIN_W-1:0] <= nxt[WIN_W-1:0]; edge_q <= nxt[WIN_W];
      end
      if (wr_cnt) cnt_q <= reg_wdata[CNT_W-1:0];
      else if (fire && cnt_en) cnt_q <= cnt_q - CNT_W'(step);
      if (wr_tst) test_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie <= 1'b0; dir <= 1'b0; en <= 1'b0; cnt_en <= 1'b0; bsel <= 2'b00; tc_quiet <= 1'b0;
      f_irq <= 1'b0; f_err <= 1'b0; f_tc <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ie <= reg_wdata[4]; dir <= reg_wdata[8]; en <= reg_wdata[9];
        cnt_en <= reg_wdata[13]; bsel <= reg_wdata[19:18]; tc_quiet <= reg_wdata[23];
      end
      f_tc  <= last | (f_tc & ~(wr_ctl & reg_wdata[14]));
      f_irq <= (last & ~tc_quiet) | (f_irq & ~(wr_ctl & reg_wdata[0]));
      f_err <= hit_err | (f_err & ~(wr_ctl & reg_wdata[1]));
    end
  end

  assign irq = ie & (f_irq | f_err);

  logic [31:0] csr;
  always_comb begin
    csr = '0;
    csr[31:28] = DEV_ID;
    csr[0] = f_irq;  csr[1] = f_err;  csr[4] = ie;
    csr[8] = dir;    csr[9] = en;     csr[13] = cnt_en;
    csr[14] = f_tc;  csr[19:18] = bsel; csr[23] = tc_quiet;
  end

  always_comb begin
    case (reg_idx)
      2'd0:    reg_rdata = csr;
      2'd1:    reg_rdata = addr_q;
      2'd2:    reg_rdata = 32'(cnt_q);
      default: reg_rdata = test_q;
    endcase
  end

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mem_req_valid);
  p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt == FULL |-> !dev_in_ready);
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cnt_en && !wr_cnt |=> cnt_q == $past(cnt_q) - CNT_W'($past(step)));
  p_len_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst |=> !in_burst || $stable(blen_q));
  p_tc_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last && !tc_quiet |=> f_irq && f_tc);
  p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !wr_adr |=> addr_q[WIN_W-1:0] == '0 || addr_q[WIN_W-1:0] > $past(addr_q[WIN_W-1:0]));
  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && reg_wdata[1] && !hit_err |=> !f_err);
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fcnt == '0);

endmodule

// File: tb/dma_channel_bench.sv
module dma_channel_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dev_in_valid = 1'b0, dev_in_ready;
  logic [31:0] dev_in_data = '0;
  logic dev_out_valid, dev_out_ready = 1'b0;
  logic [31:0] dev_out_data;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [31:0] mem_req_addr, mem_wdata, mem_rdata;
  logic [4:0] mem_req_len;
  logic irq;

  dma_channel u_dma_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_write(mem_req_write), .mem_req_len(mem_req_len), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq));

  int checks = 0, errors = 0, cyc = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic int words(input int n);
    return (n + 3) / 4;
  endfunction
  function automatic int bw(input int b);
    case (b)
      0: return 4;
      1: return 8;
      3: return 16;
      default: return 1;
    endcase
  endfunction

  assign mem_rdata = pat(mem_req_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] src [0:255];
  logic [31:0] rbuf [0:255];
  int src_n = 0, src_i = 0, rb_w = 0, rb_r = 0, mem_idx = 0;
  logic [31:0] exp_addr = '0;
  int exp_rem = 0, bw_cur = 4, bleft = 0, st = 0, elen = 0;
  bit exp_cnt = 1'b1, exp_dir = 1'b0, rnd_on = 1'b1, exp_idle = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_idle) check(!mem_req_valid, "R3 no request while disabled", 32'(mem_req_valid), 0);
      if (mem_req_valid && mem_req_ready) begin
        st = (exp_cnt && exp_rem < 4) ? exp_rem : 4;
        check(mem_req_addr == exp_addr, "R5 beat address", mem_req_addr, exp_addr);
        if (bleft == 0) begin
          elen = (exp_cnt && words(exp_rem) < bw_cur) ? words(exp_rem) : bw_cur;
          check(mem_req_len == 5'(elen), "R6 burst length", 32'(mem_req_len), elen);
          bleft = elen;
        end else begin
          check(mem_req_len == 5'(elen), "R6 length held in burst", 32'(mem_req_len), elen);
        end
        bleft--;
        check(mem_req_write == exp_dir, "R4 beat direction", 32'(mem_req_write), 32'(exp_dir));
        if (exp_dir) begin
          check(mem_wdata == src[mem_idx], "R4 write data order", mem_wdata, src[mem_idx]);
          mem_idx++;
        end else begin
          rbuf[rb_w] = mem_rdata;
          rb_w++;
        end
        exp_addr += 32'(st);
        exp_rem -= st;
      end
      if (dev_out_valid && dev_out_ready) begin
        check(dev_out_data == rbuf[rb_r], "R4 read data order", dev_out_data, rbuf[rb_r]);
        rb_r++;
      end
      if (dev_in_valid && dev_in_ready) src_i++;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rnd_on) begin
      mem_req_ready = ($urandom % 4) != 0;
      dev_out_ready = ($urandom % 3) != 0;
    end
    dev_in_valid = (src_i < src_n) && (($urandom % 4) != 0);
    dev_in_data  = src[src_i];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog R1..all actual=%0d expected<%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_idx = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    reg_idx = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_flag(input logic [31:0] mask);
    logic [31:0] v;
    v = '0;
    while ((v & mask) == 0) rd(2'd0, v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic start(input bit d, input int b, input logic [31:0] a, input int n, input logic [31:0] extra);
    wr(2'd0, 32'h0000_4023 | (32'(d) << 8));
    exp_addr = a; exp_rem = n; exp_cnt = 1'b1; exp_dir = d;
    bw_cur = bw(b); bleft = 0; mem_idx = 0; rb_w = 0; rb_r = 0;
    src_i = 0; src_n = 0;
    if (d) begin
      for (int k = 0; k < words(n); k++) src[k] = $urandom;
      src_n = words(n);
    end
    wr(2'd1, a);
    wr(2'd2, 32'(n));
    wr(2'd0, 32'h0000_2210 | (32'(d) << 8) | (32'(b) << 18) | extra);
  endtask

  task automatic finish_move(input bit d);
    if (!d) while (rb_r < rb_w) @(negedge clk);
  endtask

  logic [31:0] v, c1, c2, cfg;

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    @(posedge clk); #1; rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check(v == 32'hA000_0000, "R1 control at reset", v, 32'hA000_0000);
    rd(2'd1, v); check(v == 0, "R1 address at reset", v, 0);
    rd(2'd2, v); check(v == 0, "R1 count at reset", v, 0);
    rd(2'd3, v); check(v == 0, "R1 scratch at reset", v, 0);
    check(!irq && !mem_req_valid, "R1 outputs idle", {30'd0, irq, mem_req_valid}, 0);

    // R2 register access
    wr(2'd3, 32'hDEAD_BEEF); rd(2'd3, v); check(v == 32'hDEAD_BEEF, "R2 scratch", v, 32'hDEAD_BEEF);
    wr(2'd1, 32'h1234_5678); rd(2'd1, v); check(v == 32'h1234_5678, "R2 address", v, 32'h1234_5678);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check(v == 32'h00FF_FFFF, "R2 count width", v, 32'h00FF_FFFF);
    wr(2'd0, 32'hFF8C_0130); rd(2'd0, v); check(v == 32'hA08C_0110, "R2 control fields", v, 32'hA08C_0110);
    wr(2'd0, 32'h0000_0000);

    // R4 R5 R6 R7 R9 random transfers
    for (int it = 0; it < 10; it++) begin
      bit d;
      int b, n;
      logic [31:0] a;
      d = 1'($urandom % 2);
      b = $urandom % 4;
      n = 1 + ($urandom % 150);
      a = 32'h4000_0000 | ($urandom & 32'h000F_FFFC);
      start(d, b, a, n, 32'h0);
      wait_flag(32'h0000_4002);
      finish_move(d);
      rd(2'd1, v); check(v == a + 32'(n), "R5 final address", v, a + 32'(n));
      rd(2'd2, v); check(v == 0, "R5 count drained", v, 0);
      rd(2'd0, v); check((v & 32'h0000_4003) == 32'h0000_4001, "R7 terminal count flags", v & 32'h4003, 32'h4001);
      check(irq == 1'b1, "R9 irq on terminal count", 32'(irq), 1);
      check((d ? mem_idx : rb_w) == words(n), "R4 beats moved", 32'(d ? mem_idx : rb_w), 32'(words(n)));
    end

    // R7 terminal count with interrupt suppressed
    start(1'b0, 1, 32'h4000_2000, 20, 32'h0080_0000);
    wait_flag(32'h0000_4002);
    finish_move(1'b0);
    rd(2'd0, v); check((v & 32'h0000_4001) == 32'h0000_4000, "R7 quiet terminal count", v & 32'h4001, 32'h4000);
    check(irq == 1'b0, "R9 no irq when quiet", 32'(irq), 0);

    // R8 transfer ending exactly on the window edge
    start(1'b0, 0, 32'h12FF_FFF0, 16, 32'h0);
    wait_flag(32'h0000_4002);
    finish_move(1'b0);
    rd(2'd1, v); check(v == 32'h1200_0000, "R8 exact end address", v, 32'h1200_0000);
    rd(2'd0, v); check((v & 32'h0000_4003) == 32'h0000_4001, "R8 exact end no error", v & 32'h4003, 32'h4001);

    // R8 transfer that would cross the window edge
    start(1'b0, 0, 32'h12FF_FFF0, 64, 32'h0);
    wait_flag(32'h0000_4002);
    finish_move(1'b0);
    rd(2'd1, v); check(v == 32'h1200_0000, "R8 stop at edge", v, 32'h1200_0000);
    rd(2'd2, v); check(v == 48, "R8 remaining count kept", v, 48);
    rd(2'd0, v); check((v & 32'h0000_4003) == 32'h0000_0002, "R8 error flag", v & 32'h4003, 32'h2);
    check(irq == 1'b1, "R9 irq on error", 32'(irq), 1);
    check(rb_w == 4, "R8 beats before edge", 32'(rb_w), 4);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, v);
    check(irq == 1'b0, "R9 irq masked by bit 4", 32'(irq), 0);
    check(v[1] == 1'b1, "R10 zero write keeps error", 32'(v[1]), 1);
    wr(2'd0, 32'h0000_0002);
    rd(2'd0, v); check(v[1] == 1'b0, "R10 error cleared", 32'(v[1]), 0);

    // R3 clearing enable halts requests
    start(1'b0, 0, 32'h4000_0100, 400, 32'h0);
    idle(20);
    wr(2'd0, 32'h0000_2010);
    exp_idle = 1'b1;
    rd(2'd2, c1);
    rd(2'd1, v);
    idle(30);
    rd(2'd2, c2);
    rd(2'd1, cfg);
    exp_idle = 1'b0;
    check(c1 == c2, "R3 count frozen", c2, c1);
    check(v == cfg, "R3 address frozen", cfg, v);
    check(c1 < 400 && c1 > 0, "R3 stopped mid transfer", c1, 1);

    // R11 flush drops queued words
    wr(2'd0, 32'h0000_4123);
    src[0] = 32'hAAAA_0001; src[1] = 32'hAAAA_0002; src[2] = 32'hAAAA_0003;
    src_i = 0; src_n = 3;
    idle(15);
    wr(2'd0, 32'h0000_0120);
    src[3] = 32'h7777_1234;
    mem_idx = 3; exp_addr = 32'h4000_0400; exp_rem = 4; exp_cnt = 1'b1; exp_dir = 1'b1;
    bw_cur = 1; bleft = 0;
    wr(2'd1, 32'h4000_0400);
    wr(2'd2, 32'd4);
    wr(2'd0, 32'h0008_2310);
    src_n = 4;
    wait_flag(32'h0000_4002);
    check(mem_idx == 4, "R11 only new word written", 32'(mem_idx), 4);
    rd(2'd0, v); check(v[1] == 1'b0, "R11 no error", 32'(v[1]), 0);

    // R10 clear coinciding with terminal count
    rnd_on = 1'b0;
    mem_req_ready = 1'b0; dev_out_ready = 1'b1;
    wr(2'd0, 32'h0000_4023);
    exp_addr = 32'h4000_0800; exp_rem = 4; exp_dir = 1'b0; bw_cur = 1; bleft = 0;
    rb_w = 0; rb_r = 0;
    wr(2'd1, 32'h4000_0800);
    wr(2'd2, 32'd4);
    cfg = 32'h0008_2210;
    wr(2'd0, cfg);
    idle(4);
    @(posedge clk); #1;
    mem_req_ready = 1'b1;
    reg_wr = 1'b1; reg_idx = 2'd0; reg_wdata = cfg | 32'h0000_4001;
    @(posedge clk); #1;
    mem_req_ready = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v);
    check((v & 32'h0000_4001) == 32'h0000_4001, "R10 set wins over clear", v & 32'h4001, 32'h4001);
    check(irq == 1'b1, "R10 irq kept", 32'(irq), 1);
    check(rb_w == 1, "R10 beat taken", 32'(rb_w), 1);
    wr(2'd0, cfg | 32'h0000_4001);
    rd(2'd0, v);
    check((v & 32'h0000_4001) == 32'h0, "R10 flags cleared", v & 32'h4001, 0);
    check(irq == 1'b0, "R10 irq removed", 32'(irq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule